// File: doc/BRIEF.md
# Clear-to-Send Transmit Gate

This block decides when a serial transmitter may begin a character and when it must stop early. It is clocked by the transmit bit clock and watches an active-low clear-to-send input. A 2-bit enable-mode field selects how the transmitter is enabled. It can be off, on without condition, or gated by clear-to-send. In gated mode, a character can start only while clear-to-send is low. The start strobe is placed on a falling bit-clock edge, so the latency from the first rising edge that sees clear-to-send low is a whole number of periods plus one half.

Once a character is under way, removing clear-to-send has one of two effects. In asynchronous framing, the current character is finished and the transmitter then goes idle. In synchronous framing, an abort strobe tells the shifter to stop at once and return the data line to idle. The shifter is a separate block: it receives the start and abort strobes and reports back through a ready flag and a character-done flag.

Top module: `cts_tx_gate`

## Requirements
- R1: While rst_n is low, start_pulse and abort_pulse are 0, and the block leaves reset idle.
- R2: With txen_mode 2'b00 (off) or 2'b10 (held off), no start_pulse is produced, whatever the values of cts_n and tx_ready.
- R3: With txen_mode 2'b11 (gated), let rising edge k be the first one that samples cts_n low and tx_ready high while the block is idle. Provided both stay that way through edge k+4, start_pulse rises at the falling edge 4.5 periods after edge k (default START_WHOLE_CLKS=4). It stays high for exactly one bit-clock period.
- R4: With txen_mode 2'b01 (on), tx_ready alone starts a character after the same 4.5-period latency. cts_n has no effect in this mode, and no abort_pulse is produced even in synchronous framing.
- R5: With txen_mode 2'b11 and cts_n held high, no start_pulse is produced.
- R6: In gated mode, if cts_n is sampled high during the start latency, the pending start is cancelled. A later start needs cts_n to be sampled low again and then the full 4.5-period latency.
- R7: With sync_mode 0 (asynchronous), cts_n going high during a character produces no abort_pulse. The block waits for char_done and then goes idle, and it starts nothing more while cts_n stays high.
- R8: With sync_mode 1 and txen_mode 2'b11, cts_n sampled high during a character drives abort_pulse high for one period, starting at that rising edge. The block then goes idle, and the next start needs cts_n low again plus the full latency.
- R9: Exactly one start_pulse is produced per character. Another start can follow only after char_done has been sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Active-low clear-to-send, synchronous to bit_clk |
| txen_mode | input | 2 | 00 off, 01 on, 10 held off, 11 gated by clear-to-send |
| sync_mode | input | 1 | 1 selects synchronous framing, 0 asynchronous |
| tx_ready | input | 1 | The shifter has a character ready to send |
| char_done | input | 1 | The shifter finished the current character |
| start_pulse | output | 1 | One-period start strobe, launched on a falling edge |
| abort_pulse | output | 1 | One-period strobe that stops synchronous transmission |

## Verification
The bench builds the block with its default START_WHOLE_CLKS of 4, which gives the 4.5-period start latency. With that value, every start window and cancellation point lies within a few cycles of the stimulus. Clear-to-send is withdrawn on the second cycle of the latency, which cancels a launch two edges before it would fire. Each framing mode is also made to drop clear-to-send in the middle of a character. The scoreboard gives every expected strobe an exact cycle number, so a strobe that is one cycle late, one cycle wide too many, or missing shows up as a mismatch.

// File: rtl/ctsg_pkg.sv
package ctsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } ctsg_state_e;

    localparam logic [1:0] MODE_OFF  = 2'b00;
    localparam logic [1:0] MODE_ON   = 2'b01;
    localparam logic [1:0] MODE_HOLD = 2'b10;
    localparam logic [1:0] MODE_AUTO = 2'b11;

endpackage

// File: rtl/ctsg_gate_decode.sv
module ctsg_gate_decode
    import ctsg_pkg::*;
(
    input  logic [1:0] txen_mode,
    input  logic       cts_n,
    input  logic       tx_ready,
    output logic       go,
    output logic       auto_gate
);
    always_comb begin
        auto_gate = (txen_mode == MODE_AUTO);
        unique case (txen_mode)
            MODE_ON:   go = tx_ready;
            MODE_AUTO: go = tx_ready && !cts_n;
            default:   go = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctsg_ctrl.sv
module ctsg_ctrl
    import ctsg_pkg::*;
#(
    parameter int START_WHOLE_CLKS = 4
) (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic go,
    input  logic auto_gate,
    input  logic cts_n,
    input  logic sync_mode,
    input  logic char_done,
    output logic launch,
    output logic abort
);
    localparam int CNT_W = (START_WHOLE_CLKS > 1) ? $clog2(START_WHOLE_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(START_WHOLE_CLKS - 1);

    typedef struct packed {
        ctsg_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic             launch;
        logic             abort;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.launch = 1'b0;
        st_d.abort  = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (go) begin
                    st_d.state = ST_WAIT;
                    st_d.cnt   = '0;
                end
            end
            ST_WAIT: begin
                if (!go) begin
                    st_d.state = ST_IDLE;
                end else if (st_q.cnt == CNT_LAST) begin
                    st_d.state  = ST_SEND;
                    st_d.launch = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            ST_SEND: begin
                if (char_done) begin
                    st_d.state = ST_IDLE;
                end else if (auto_gate && cts_n && sync_mode) begin
                    st_d.state = ST_IDLE;
                    st_d.abort = 1'b1;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, cnt: '0, launch: 1'b0, abort: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign launch = st_q.launch;
    assign abort  = st_q.abort;
endmodule

// File: rtl/ctsg_half_retime.sv
module ctsg_half_retime (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic q_d, q_q;

    always_comb q_d = d;

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/cts_tx_gate.sv
module cts_tx_gate #(
    parameter int START_WHOLE_CLKS = 4
) (
    input  logic       bit_clk,
    input  logic       rst_n,
    input  logic       cts_n,
    input  logic [1:0] txen_mode,
    input  logic       sync_mode,
    input  logic       tx_ready,
    input  logic       char_done,
    output logic       start_pulse,
    output logic       abort_pulse
);
    logic go, auto_gate, launch;

    ctsg_gate_decode u_dec (
        .txen_mode (txen_mode),
        .cts_n     (cts_n),
        .tx_ready  (tx_ready),
        .go        (go),
        .auto_gate (auto_gate)
    );

    ctsg_ctrl #(.START_WHOLE_CLKS(START_WHOLE_CLKS)) u_ctrl (
        .bit_clk   (bit_clk),
        .rst_n     (rst_n),
        .go        (go),
        .auto_gate (auto_gate),
        .cts_n     (cts_n),
        .sync_mode (sync_mode),
        .char_done (char_done),
        .launch    (launch),
        .abort     (abort_pulse)
    );

    ctsg_half_retime u_half (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .d       (launch),
        .q       (start_pulse)
    );
endmodule

// File: rtl/cts_tx_gate_chk.sv
module cts_tx_gate_chk (
    input logic       bit_clk,
    input logic       rst_n,
    input logic       cts_n,
    input logic [1:0] txen_mode,
    input logic       sync_mode,
    input logic       start_pulse,
    input logic       abort_pulse
);
    always @(posedge bit_clk) begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (!start_pulse && !abort_pulse);
        end
    end

    a_r2_start_needs_enable: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(start_pulse) |-> $past(txen_mode[0]));

    a_r5_gated_start_needs_cts: assert property (@(posedge bit_clk) disable iff (!rst_n)
        ($rose(start_pulse) && $past(txen_mode) == 2'b11) |-> !$past(cts_n));

    a_r3_start_one_period: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(start_pulse) |=> !start_pulse);

    a_r8_abort_cause: assert property (@(posedge bit_clk) disable iff (!rst_n)
        abort_pulse |-> ($past(sync_mode) && $past(cts_n) && $past(txen_mode) == 2'b11));

    a_r8_abort_one_period: assert property (@(posedge bit_clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);
endmodule

bind cts_tx_gate cts_tx_gate_chk u_chk (
    .bit_clk     (bit_clk),
    .rst_n       (rst_n),
    .cts_n       (cts_n),
    .txen_mode   (txen_mode),
    .sync_mode   (sync_mode),
    .start_pulse (start_pulse),
    .abort_pulse (abort_pulse)
);

// File: tb/sim_cts_tx_gate.sv
module sim_cts_tx_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       cts_n = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       sync = 1'b0;
    logic       rdy = 1'b0;
    logic       done = 1'b0;
    logic       start_pulse, abort_pulse;

    always #2 clk = ~clk;

    cts_tx_gate u0 (
        .bit_clk     (clk),
        .rst_n       (rst_n),
        .cts_n       (cts_n),
        .txen_mode   (mode),
        .sync_mode   (sync),
        .tx_ready    (rdy),
        .char_done   (done),
        .start_pulse (start_pulse),
        .abort_pulse (abort_pulse)
    );

    typedef struct {
        int    cyc;
        string tag;
    } exp_t;

    exp_t  sq[$];
    exp_t  aq[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    strobes = 0;
    bit    running = 1'b0;
    bit    finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: samples 3 ns after each rising edge, after the falling edge
    always @(posedge clk) begin
        #3;
        if (running) begin
            if (start_pulse) begin
                strobes++;
                if (sq.size() > 0 && sq[0].cyc == cyc) begin
                    chk(1'b1, sq[0].tag, "start cycle", cyc, sq[0].cyc);
                    void'(sq.pop_front());
                end else begin
                    chk(1'b0, "R9", "unexpected start at cycle", cyc,
                        (sq.size() > 0) ? sq[0].cyc : -1);
                end
            end else if (sq.size() > 0 && sq[0].cyc <= cyc) begin
                chk(1'b0, sq[0].tag, "missing start", 0, 1);
                void'(sq.pop_front());
            end
            if (abort_pulse) begin
                strobes++;
                if (aq.size() > 0 && aq[0].cyc == cyc) begin
                    chk(1'b1, aq[0].tag, "abort cycle", cyc, aq[0].cyc);
                    void'(aq.pop_front());
                end else begin
                    chk(1'b0, "R7", "unexpected abort at cycle", cyc,
                        (aq.size() > 0) ? aq[0].cyc : -1);
                end
            end else if (aq.size() > 0 && aq[0].cyc <= cyc) begin
                chk(1'b0, aq[0].tag, "missing abort", 0, 1);
                void'(aq.pop_front());
            end
        end
    end

    task automatic at_edge();
        @(posedge clk);
        #1;
    endtask

    // start is visible 5 samples after the drive (edge k+4, then falling edge)
    task automatic expect_start(input string tag);
        sq.push_back('{cyc + 5, tag});
    endtask

    task automatic expect_abort(input string tag);
        aq.push_back('{cyc + 1, tag});
    endtask

    task automatic quiet(input int n, input string tag);
        int s;
        s = strobes;
        repeat (n) at_edge();
        chk(strobes == s, tag, "strobes in quiet window", strobes - s, 0);
    endtask

    task automatic end_char();
        at_edge();
        done = 1'b1;
        at_edge();
        done = 1'b0;
        rdy  = 1'b0;
        at_edge();
    endtask

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        chk(start_pulse == 1'b0 && abort_pulse == 1'b0, "R1", "strobes in reset",
            {start_pulse, abort_pulse}, 0);
        at_edge();
        rst_n = 1'b1;
        running = 1'b1;

        // R2: off and held-off modes ignore clear-to-send
        at_edge(); mode = 2'b00; rdy = 1'b1; cts_n = 1'b0;
        quiet(12, "R2");
        at_edge(); mode = 2'b10;
        quiet(12, "R2");

        // R5: gated with clear-to-send high
        at_edge(); mode = 2'b11; cts_n = 1'b1;
        quiet(12, "R5");

        // R3: gated start latency
        at_edge(); cts_n = 1'b0; expect_start("R3");
        repeat (9) at_edge();
        end_char();

        // R9: next start only after char_done
        at_edge(); rdy = 1'b1; expect_start("R9");
        repeat (8) at_edge();
        end_char();

        // R4: unconditional mode, cts ignored, no abort in sync framing
        at_edge(); mode = 2'b01; cts_n = 1'b1; rdy = 1'b1; expect_start("R4");
        repeat (7) at_edge();
        sync = 1'b1;
        at_edge(); cts_n = 1'b0;
        at_edge(); cts_n = 1'b1;
        quiet(4, "R4");
        end_char();

        // R6: cancel during latency, then full latency from new low
        at_edge(); mode = 2'b11; sync = 1'b0; cts_n = 1'b0; rdy = 1'b1;
        at_edge();
        at_edge(); cts_n = 1'b1;
        quiet(10, "R6");
        at_edge(); cts_n = 1'b0; expect_start("R6");
        repeat (8) at_edge();
        end_char();

        // R7: asynchronous framing finishes the character
        at_edge(); rdy = 1'b1; cts_n = 1'b0; expect_start("R7");
        repeat (6) at_edge();
        cts_n = 1'b1;
        quiet(6, "R7");
        end_char();
        at_edge(); rdy = 1'b1;
        quiet(10, "R7");
        at_edge(); cts_n = 1'b0; expect_start("R7");
        repeat (8) at_edge();
        end_char();

        // R8: synchronous framing aborts at once
        at_edge(); sync = 1'b1; rdy = 1'b1; cts_n = 1'b0; expect_start("R8");
        repeat (6) at_edge();
        cts_n = 1'b1; expect_abort("R8");
        repeat (6) at_edge();
        at_edge(); cts_n = 1'b0; expect_start("R8");
        repeat (8) at_edge();
        end_char();

        repeat (10) at_edge();
        chk(sq.size() == 0 && aq.size() == 0, "R3", "pending expectations",
            sq.size() + aq.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule